// File: doc/BRIEF.md
# Prefetching Flash Line Buffer

This block sits between a 32-bit read port and a flash bank that delivers one 128-bit line per access after a fixed latency. It holds four lines, each tagged with its line address. A read that finds its line in the buffer returns the selected 32-bit word with no wait state. A read that misses starts a flash line read and returns its word once that line arrives.

After each demand fill of line N, the controller fetches line N+1 in the background. In-order code fetches then run into lines that are already buffered. Only one flash access is outstanding at a time. A demand read for a line that is already on its way waits for that transfer and does not request the line a second time. An invalidate input empties the buffer in one cycle.

Top module: `pfbuf`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rd_ready_o` is 1, `rd_valid_o` is 0 and `fl_req_o` is 0.
- R2: A read accepted in cycle T (`rd_req_i` and `rd_ready_o` both 1) whose line is buffered returns a word in cycle T+1 with `rd_valid_o` = 1. That word is bits [32*k+31:32*k] of the line, where k = `rd_addr_i[3:2]`. A read whose line is buffered adds no flash request.
- R3: A read that misses while the flash is idle raises `fl_req_o` in its accept cycle, with `fl_addr_o` = `rd_addr_i[AW-1:4]`. `rd_ready_o` is 0 until the word appears in the cycle after `fl_valid_i`. With a 2-cycle flash, the word arrives 3 cycles after acceptance.
- R4: One cycle after the word of a demand fill of line N is returned, line N+1 is requested from the flash if it is not buffered. If it is already buffered, no request is made.
- R5: Fills take victims in round-robin order across the four entries. A background fetch never takes the entry that the last demand fill wrote.
- R6: A demand read for the line that is currently being fetched in the background issues no new flash request. It completes in the cycle after that fill arrives. If it is accepted in the very cycle the fill arrives, it completes one cycle later.
- R7: A demand miss accepted while the flash is busy with a different line waits for that transfer to finish. It then issues its own request in the cycle the transfer completes.
- R8: A cycle with `inval_i` = 1 leaves no entry valid. A read accepted afterwards misses.
- R9: `fl_req_o` is never raised while an earlier flash request is outstanding, except in the cycle whose `fl_valid_i` completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| inval_i | input | 1 | Clears every buffered entry |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | AW | Byte address of the read |
| rd_ready_o | output | 1 | Controller can accept a read this cycle |
| rd_valid_o | output | 1 | Read word is valid |
| rd_data_o | output | 32 | Read word |
| fl_req_o | output | 1 | Flash line read request (one cycle) |
| fl_addr_o | output | AW-4 | Line address of the flash request |
| fl_valid_i | input | 1 | Flash line data is valid this cycle |
| fl_line_i | input | 128 | Flash line data |

## Verification
The latency of each result is counted from the accept edge:
- A hit is due 1 cycle later.
- A cold miss is due 3 cycles later with the 2-cycle flash model.
- A read that joins a background fetch already in flight is due 2 cycles later.
- A read that waits behind a different background fetch is due 4 cycles later.
- A read accepted in the cycle the fill arrives is due 1 cycle later.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from acceptance until `rd_valid_o` appears and compares that count with the expected latency, as well as comparing the word. Background fetches are checked through the flash request count after idle gaps, and through whether later reads hit or miss.

// File: rtl/pfbuf_pkg.sv
package pfbuf_pkg;
    localparam int WORD_W = 32;
    localparam int LINE_W = 128;
    localparam int WPL    = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WPL);
    localparam int OFS_W  = WSEL_W + 2;
endpackage

// File: rtl/pfbuf_tag_match.sv
module pfbuf_tag_match #(
    parameter int N  = 4,
    parameter int TW = 12,
    parameter int SW = 2
) (
    input  logic [N-1:0]         vld_i,
    input  logic [N-1:0][TW-1:0] tags_i,
    input  logic [TW-1:0]        key_i,
    output logic                 hit_o,
    output logic [SW-1:0]        slot_o
);
    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = vld_i[i] && (tags_i[i] == key_i);
    end

    always_comb begin
        hit_o  = |eq;
        slot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) slot_o = SW'(i);
        end
    end
endmodule

// File: rtl/pfbuf_word_sel.sv
module pfbuf_word_sel
    import pfbuf_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  logic [WSEL_W-1:0] sel_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WPL-1:0][WORD_W-1:0] w;

    for (genvar i = 0; i < WPL; i++) begin : g_w
        assign w[i] = line_i[i*WORD_W +: WORD_W];
    end

    assign word_o = w[sel_i];
endmodule

// File: rtl/pfbuf.sv
module pfbuf
    import pfbuf_pkg::*;
#(
    parameter int AW      = 16,
    parameter int N_LINES = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                inval_i,
    input  logic                rd_req_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic                rd_ready_o,
    output logic                rd_valid_o,
    output logic [WORD_W-1:0]   rd_data_o,
    output logic                fl_req_o,
    output logic [AW-OFS_W-1:0] fl_addr_o,
    input  logic                fl_valid_i,
    input  logic [LINE_W-1:0]   fl_line_i
);
    localparam int TW = AW - OFS_W;
    localparam int SW = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam logic [TW-1:0] ONE_T = 1;
    localparam logic [SW-1:0] ONE_S = 1;

    typedef struct packed {
        logic [N_LINES-1:0]             vld;
        logic [N_LINES-1:0][TW-1:0]     tag;
        logic [N_LINES-1:0][LINE_W-1:0] dat;
        logic [SW-1:0]                  rr;
        logic                           fbusy;
        logic [TW-1:0]                  ftag;
        logic [SW-1:0]                  fslot;
        logic                           fkeep;
        logic                           dpend;
        logic                           datt;
        logic [TW-1:0]                  dtag;
        logic [WSEL_W-1:0]              dword;
        logic                           pwant;
        logic [TW-1:0]                  ptag;
        logic                           pv;
        logic [SW-1:0]                  pslot;
        logic                           rv;
        logic [WORD_W-1:0]              rdat;
    } st_t;

    st_t s_d, s_q;

    logic [TW-1:0]     req_tag;
    logic [WSEL_W-1:0] req_word;
    logic [1:0]        addr_unused;
    logic              req_hit, pf_hit;
    logic [SW-1:0]     hit_slot, pf_slot_unused;
    logic [WORD_W-1:0] hit_word, fill_word, fwd_word;
    logic              accept, fill_now, flash_free;
    logic              iss, iss_dem;
    logic [TW-1:0]     iss_tag;
    logic [SW-1:0]     vic;

    assign req_tag     = rd_addr_i[AW-1:OFS_W];
    assign req_word    = rd_addr_i[OFS_W-1:2];
    assign addr_unused = rd_addr_i[1:0];
    assign accept      = rd_req_i && !s_q.dpend;
    assign fill_now    = fl_valid_i && s_q.fbusy;
    assign flash_free  = !s_q.fbusy || fl_valid_i;

    pfbuf_tag_match #(.N(N_LINES), .TW(TW), .SW(SW)) u_req_match (
        .vld_i(s_q.vld), .tags_i(s_q.tag), .key_i(req_tag),
        .hit_o(req_hit), .slot_o(hit_slot)
    );

    pfbuf_tag_match #(.N(N_LINES), .TW(TW), .SW(SW)) u_pf_match (
        .vld_i(s_q.vld), .tags_i(s_q.tag), .key_i(s_q.ptag),
        .hit_o(pf_hit), .slot_o(pf_slot_unused)
    );

    pfbuf_word_sel u_sel_hit  (.line_i(s_q.dat[hit_slot]), .sel_i(req_word), .word_o(hit_word));
    pfbuf_word_sel u_sel_fill (.line_i(fl_line_i), .sel_i(s_q.dword), .word_o(fill_word));
    pfbuf_word_sel u_sel_fwd  (.line_i(fl_line_i), .sel_i(req_word), .word_o(fwd_word));

    always_comb begin
        s_d       = s_q;
        s_d.rv    = 1'b0;
        fl_req_o  = 1'b0;
        fl_addr_o = '0;
        iss       = 1'b0;
        iss_dem   = 1'b0;
        iss_tag   = '0;
        vic       = '0;

        // line arrival from flash
        if (fill_now) begin
            s_d.fbusy = 1'b0;
            if (s_q.fkeep) begin
                s_d.vld[s_q.fslot] = 1'b1;
                s_d.tag[s_q.fslot] = s_q.ftag;
                s_d.dat[s_q.fslot] = fl_line_i;
            end
            if (s_q.dpend && s_q.datt) begin
                s_d.rv    = 1'b1;
                s_d.rdat  = fill_word;
                s_d.dpend = 1'b0;
                s_d.datt  = 1'b0;
                s_d.pv    = s_q.fkeep;
                s_d.pslot = s_q.fslot;
                s_d.pwant = 1'b1;
                s_d.ptag  = s_q.ftag + ONE_T;
            end
        end

        // new demand read
        if (accept) begin
            if (req_hit) begin
                s_d.rv   = 1'b1;
                s_d.rdat = hit_word;
            end else if (fill_now && s_q.ftag == req_tag) begin
                s_d.rv    = 1'b1;
                s_d.rdat  = fwd_word;
                s_d.pv    = s_q.fkeep;
                s_d.pslot = s_q.fslot;
                s_d.pwant = 1'b1;
                s_d.ptag  = req_tag + ONE_T;
            end else begin
                s_d.dpend = 1'b1;
                s_d.datt  = s_q.fbusy && !fill_now && (s_q.ftag == req_tag);
                s_d.dtag  = req_tag;
                s_d.dword = req_word;
                s_d.pwant = 1'b0;
            end
        end

        if (inval_i) begin
            s_d.vld   = '0;
            s_d.pwant = 1'b0;
            s_d.pv    = 1'b0;
            s_d.fkeep = 1'b0;
        end

        // flash issue: demand first, then background fetch
        if (flash_free) begin
            if (s_d.dpend && !s_d.datt) begin
                iss     = 1'b1;
                iss_dem = 1'b1;
                iss_tag = s_d.dtag;
            end else if (s_q.pwant && s_d.pwant) begin
                if (pf_hit || (fill_now && s_q.ftag == s_q.ptag)) begin
                    s_d.pwant = 1'b0;
                end else begin
                    iss     = 1'b1;
                    iss_tag = s_q.ptag;
                end
            end
        end

        if (iss) begin
            vic = (!iss_dem && s_d.pv && s_q.rr == s_d.pslot) ? s_q.rr + ONE_S : s_q.rr;
            fl_req_o       = 1'b1;
            fl_addr_o      = iss_tag;
            s_d.vld[vic]   = 1'b0;
            s_d.rr         = vic + ONE_S;
            s_d.fbusy      = 1'b1;
            s_d.ftag       = iss_tag;
            s_d.fslot      = vic;
            s_d.fkeep      = 1'b1;
            if (iss_dem) s_d.datt  = 1'b1;
            else         s_d.pwant = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rd_ready_o = !s_q.dpend;
    assign rd_valid_o = s_q.rv;
    assign rd_data_o  = s_q.rdat;
endmodule

// File: rtl/pfbuf_checker.sv
module pfbuf_checker #(
    parameter int N_LINES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inval,
    input logic               rd_req,
    input logic               rd_ready,
    input logic               rd_valid,
    input logic               fl_req,
    input logic               fl_valid,
    input logic [N_LINES-1:0] vld
);
    logic out_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= 1'b0;
        else if (fl_req)   out_q <= 1'b1;
        else if (fl_valid) out_q <= 1'b0;
    end

    a_r2_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_req && rd_ready) || $past(fl_valid)));

    a_r3_no_data_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |-> !rd_valid);

    a_r8_inval_empties: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> (vld == '0));

    a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (!out_q || fl_valid));
endmodule

bind pfbuf pfbuf_checker #(.N_LINES(N_LINES)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .inval(inval_i),
    .rd_req(rd_req_i), .rd_ready(rd_ready_o), .rd_valid(rd_valid_o),
    .fl_req(fl_req_o), .fl_valid(fl_valid_i), .vld(s_q.vld)
);

// File: tb/pfbuf_test.sv
module pfbuf_test;
    localparam int AW = 16;
    localparam int TW = AW - 4;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inval = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_ready, rd_valid, fl_req, fl_valid;
    logic [31:0]   rd_data;
    logic [TW-1:0] fl_addr;
    logic [127:0]  fl_line;

    int n_chk = 0, n_fail = 0, n_flreq = 0, n_overlap = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfbuf #(.AW(AW), .N_LINES(4)) uut (
        .clk_i(clk), .rst_ni(rst_n), .inval_i(inval),
        .rd_req_i(rd_req), .rd_addr_i(rd_addr),
        .rd_ready_o(rd_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .fl_req_o(fl_req), .fl_addr_o(fl_addr),
        .fl_valid_i(fl_valid), .fl_line_i(fl_line)
    );

    function automatic logic [31:0] gen_word(input logic [TW-1:0] t, input logic [1:0] w);
        return {8'hA5, 6'd0, w, 4'd0, t};
    endfunction

    function automatic logic [127:0] gen_line(input logic [TW-1:0] t);
        logic [127:0] l;
        for (int i = 0; i < 4; i++) l[i*32 +: 32] = gen_word(t, 2'(i));
        return l;
    endfunction

    // flash model: 2-cycle fixed latency
    logic [1:0]    fv = '0;
    logic [TW-1:0] fa0 = '0, fa1 = '0;
    assign fl_valid = fv[1];
    assign fl_line  = gen_line(fa1);

    always @(posedge clk) begin
        fv  <= {fv[0], fl_req & rst_n};
        fa0 <= fl_addr;
        fa1 <= fa0;
        if (rst_n && fl_req) begin
            n_flreq <= n_flreq + 1;
            if (fv[0]) n_overlap <= n_overlap + 1;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int exp_lat, input string rq);
        int lat;
        while (!rd_ready) @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        lat = 1;
        while (!rd_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(rd_data == gen_word(a[AW-1:4], a[3:2]), {rq, " data"}, rd_data, gen_word(a[AW-1:4], a[3:2]));
        check(lat == exp_lat, {rq, " latency"}, 32'(lat), 32'(exp_lat));
    endtask

    localparam logic [AW-1:0] VA [NV] = '{16'h0100, 16'h0104, 16'h011C, 16'h0500, 16'h0518,
                                          16'h0108, 16'h0700, 16'h0104, 16'h0714, 16'h0508};
    localparam int            VL [NV] = '{3, 1, 1, 3, 1, 1, 3, 3, 1, 3};

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int base;
        idle(3);
        check(rd_ready == 1'b1 && rd_valid == 1'b0 && fl_req == 1'b0, "R1 in reset",
              {29'd0, rd_ready, rd_valid, fl_req}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_ready == 1'b1 && rd_valid == 1'b0 && fl_req == 1'b0, "R1 after reset",
              {29'd0, rd_ready, rd_valid, fl_req}, 32'h4);

        // R2 hits, R3 misses, R4 background fetch, R5 round-robin victims
        for (int v = 0; v < NV; v++) begin
            do_read(VA[v], VL[v], (VL[v] == 1) ? "R2/R4 hit" : "R3/R5 miss");
            idle(8);
        end

        // R4: next line already present -> no background request
        base = n_flreq;
        do_read(16'h04F0, 3, "R3 miss");
        idle(8);
        check(n_flreq - base == 1, "R4 no fetch of present line", 32'(n_flreq - base), 32'd1);
        do_read(16'h0110, 1, "R5 line kept");
        idle(8);

        // R7: demand miss waits behind background fetch of another line
        do_read(16'h0800, 3, "R3 miss");
        idle(1);
        do_read(16'h0904, 4, "R7 wait behind fetch");
        idle(8);

        // R6: demand joins background fetch already in flight
        base = n_flreq;
        do_read(16'h0A00, 3, "R3 miss");
        idle(1);
        do_read(16'h0A14, 2, "R6 join in-flight fetch");
        idle(8);
        check(n_flreq - base == 3, "R6 no duplicate request", 32'(n_flreq - base), 32'd3);

        // R6: demand accepted in the cycle the fill arrives
        do_read(16'h0C00, 3, "R3 miss");
        idle(2);
        do_read(16'h0C18, 1, "R6 same-cycle forward");
        idle(8);

        // R8: invalidate
        do_read(16'h0C14, 1, "R8 hit before invalidate");
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        do_read(16'h0C14, 3, "R8 miss after invalidate");
        idle(8);

        check(n_overlap == 0, "R9 single outstanding", 32'(n_overlap), 32'd0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule